// File: doc/BRIEF.md
# Two-Pass 8x8 Integer Inverse Transform

This block turns an 8x8 tile of signed 16-bit transform coefficients back into an 8x8 tile of signed 16-bit residual samples. The tile enters one row of eight coefficients per handshake beat. Once all eight rows are stored, the block runs a 1-D even/odd butterfly down each column, with the first shift amount, and writes each saturated result back in place. It then runs the same butterfly across each row, with the second shift amount, and sends every result row out through a valid/ready interface.

The 1-D kernel splits its eight inputs into two halves. The odd half (inputs 1, 3, 5, 7) is weighted by 89, 75, 50 and 18 in four sign patterns. The even half takes 64·(x0 ± x4) and the pairs 84·x2 + 35·x6 and 35·x2 − 84·x6, and combines them into four even terms. Output k is the sum of even term k and odd term k, and output 7−k is their difference. Every even term carries the rounding constant. All arithmetic is 32-bit signed. A single kernel instance serves both passes, so a tile takes eight load beats, eight column cycles and eight output beats.

Top module: `itx8_2pass`

## Requirements
- R1: After reset, in_ready is 1 and out_valid is 0.
- R2: The block accepts exactly eight rows per tile. The first accepted row is row 0, and column i of a row sits at bits [16i+15:16i] of in_row. in_ready is 0 in the cycle after the eighth row is accepted, and out_valid rises eight clock edges after that acceptance edge.
- R3: shift_a and shift_b are sampled together with row 0 of a tile, and must lie in 1..31. Changing them during the rest of the tile has no effect on its results.
- R4: Every result equals the column butterfly with shift_a, followed by the row butterfly with shift_b, applied to the stored tile (even terms: 64·x0 ± 64·x4, 84·x2 + 35·x6, 35·x2 − 84·x6; odd weights 89/75/50/18).
- R5: In each pass, 2^(shift−1) is added before an arithmetic right shift by that pass's shift, so halves round toward positive infinity.
- R6: Column-pass results are clamped to [−32768, 32767] before the row pass reads them.
- R7: Row-pass results are clamped to [−32768, 32767] on out_row.
- R8: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_row does not change.
- R9: Result rows leave in order 0..7, with column i at bits [16i+15:16i] of out_row. After the eighth output handshake, in_ready is 1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| shift_a | input | 5 | Column-pass shift, sampled with row 0 |
| shift_b | input | 5 | Row-pass shift, sampled with row 0 |
| in_valid | input | 1 | Input row present |
| in_ready | output | 1 | Block can take an input row |
| in_row | input | 128 | Eight signed 16-bit coefficients of one row |
| out_valid | output | 1 | Result row present |
| out_ready | input | 1 | Downstream takes the result row |
| out_row | output | 128 | Eight signed 16-bit residuals of one row |

## Verification
A tile holding a single DC coefficient, positive or negative, with small shifts exposes the rounding and sign handling of the shift stage. Random tiles with typical shifts check the full butterfly weights and the order of the two passes. A tile whose top row is at full scale saturates only between the passes, and a lone maximal coefficient with a tiny row shift saturates only at the output, so R6 and R7 are each tested on their own. One tile changes the shift inputs after row 0 to show that they are held, and random output stalls test that results are kept stable under backpressure.

// File: rtl/itx8_pkg.sv
// Shared definitions for the two-pass 8x8 inverse transform.
// Assumes a fixed 8-point kernel; only element widths are parameters.
package itx8_pkg;
    localparam int N  = 8;
    localparam int CW = $clog2(N);

    typedef enum logic [1:0] {
        PH_LOAD = 2'd0,
        PH_COL  = 2'd1,
        PH_EMIT = 2'd2
    } itx8_phase_e;
endpackage

// File: rtl/itx8_butterfly.sv
// Combinational 8-point even/odd inverse butterfly.
// Performs rounding, an arithmetic right shift and saturation to DW signed bits.
// Assumes 1 <= sh <= ACC_W-1; ACC_W must hold the widest sum without wrap.
module itx8_butterfly
    import itx8_pkg::*;
#(
    parameter int DW    = 16,
    parameter int ACC_W = 32,
    parameter int SH_W  = 5
) (
    input  logic [N*DW-1:0] x_flat,
    input  logic [SH_W-1:0] sh,
    output logic [N*DW-1:0] y_flat
);
    localparam logic signed [ACC_W-1:0] C1  = ACC_W'(1);
    localparam logic signed [ACC_W-1:0] C18 = ACC_W'(18);
    localparam logic signed [ACC_W-1:0] C35 = ACC_W'(35);
    localparam logic signed [ACC_W-1:0] C50 = ACC_W'(50);
    localparam logic signed [ACC_W-1:0] C64 = ACC_W'(64);
    localparam logic signed [ACC_W-1:0] C75 = ACC_W'(75);
    localparam logic signed [ACC_W-1:0] C84 = ACC_W'(84);
    localparam logic signed [ACC_W-1:0] C89 = ACC_W'(89);
    localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'((1 << (DW - 1)) - 1);
    localparam logic signed [ACC_W-1:0] SAT_LO = -(ACC_W'(1 << (DW - 1)));

    logic signed [ACC_W-1:0] x [N];
    logic signed [ACC_W-1:0] ev [4];
    logic signed [ACC_W-1:0] od [4];
    logic signed [ACC_W-1:0] z  [N];
    logic signed [ACC_W-1:0] rnd;
    logic signed [ACC_W-1:0] ee0, ee1, eo0, eo1;

    // Sign-extend each input element to the accumulator width.
    for (genvar i = 0; i < N; i++) begin : g_unpack
        assign x[i] = {{(ACC_W-DW){x_flat[i*DW+DW-1]}}, x_flat[i*DW +: DW]};
    end

    // Even and odd halves, rounding, and the final add/sub with shift.
    always_comb begin
        rnd   = C1 <<< (sh - SH_W'(1));
        od[0] = C89*x[1] + C75*x[3] + C50*x[5] + C18*x[7];
        od[1] = C75*x[1] - C18*x[3] - C89*x[5] - C50*x[7];
        od[2] = C50*x[1] - C89*x[3] + C18*x[5] + C75*x[7];
        od[3] = C18*x[1] - C50*x[3] + C75*x[5] - C89*x[7];
        ee0   = C64*x[0] + C64*x[4];
        ee1   = C64*x[0] - C64*x[4];
        eo0   = C84*x[2] + C35*x[6];
        eo1   = C35*x[2] - C84*x[6];
        ev[0] = ee0 + eo0 + rnd;
        ev[3] = ee0 - eo0 + rnd;
        ev[1] = ee1 + eo1 + rnd;
        ev[2] = ee1 - eo1 + rnd;
        for (int k = 0; k < 4; k++) begin
            z[k]       = (ev[k] + od[k]) >>> sh;
            z[N-1-k]   = (ev[k] - od[k]) >>> sh;
        end
    end

    // Clamp every shifted sum into the DW-bit signed range.
    for (genvar k = 0; k < N; k++) begin : g_sat
        logic signed [ACC_W-1:0] c;
        assign c = (z[k] > SAT_HI) ? SAT_HI : ((z[k] < SAT_LO) ? SAT_LO : z[k]);
        assign y_flat[k*DW +: DW] = c[DW-1:0];
    end
endmodule

// File: rtl/itx8_tile_buf.sv
// 8x8 register tile. A whole row can be written or a whole column rewritten,
// and a row and a column can be read at once. Assumes the two writes never coincide.
module itx8_tile_buf
    import itx8_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          row_we,
    input  logic [CW-1:0] row_idx,
    input  logic [N*DW-1:0] row_wdata,
    input  logic          col_we,
    input  logic [CW-1:0] col_idx,
    input  logic [N*DW-1:0] col_wdata,
    output logic [N*DW-1:0] row_rdata,
    output logic [N*DW-1:0] col_rdata
);
    logic [DW-1:0] mem [N][N];

    // Row load from the input side, or in-place column update from pass one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < N; r++)
                for (int c = 0; c < N; c++)
                    mem[r][c] <= '0;
        end else if (row_we) begin
            for (int c = 0; c < N; c++)
                mem[row_idx][c] <= row_wdata[c*DW +: DW];
        end else if (col_we) begin
            for (int r = 0; r < N; r++)
                mem[r][col_idx] <= col_wdata[r*DW +: DW];
        end
    end

    // Row and column read ports.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            row_rdata[i*DW +: DW] = mem[row_idx][i];
            col_rdata[i*DW +: DW] = mem[i][col_idx];
        end
    end

    // R2: the loading phase and the column pass never write in the same cycle.
    p_single_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(row_we && col_we));
endmodule

// File: rtl/itx8_2pass.sv
// Two-pass 8x8 inverse transform: load eight rows, transform each column in place
// with shift A, then transform each row with shift B while emitting it.
// Assumes shifts in 1..31; both are sampled with row 0 of each tile.
module itx8_2pass
    import itx8_pkg::*;
#(
    parameter int DW    = 16,
    parameter int ACC_W = 32,
    parameter int SH_W  = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [SH_W-1:0] shift_a,
    input  logic [SH_W-1:0] shift_b,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [N*DW-1:0] in_row,
    output logic            out_valid,
    input  logic            out_ready,
    output logic [N*DW-1:0] out_row
);
    itx8_phase_e     phase;
    logic [CW-1:0]   cnt;
    logic [SH_W-1:0] sha_q, shb_q;
    logic            in_fire, out_fire, last;
    logic [N*DW-1:0] row_rd, col_rd, kern_x, kern_y;
    logic [SH_W-1:0] kern_sh;

    assign in_ready  = (phase == PH_LOAD);
    assign out_valid = (phase == PH_EMIT);
    assign in_fire   = in_valid && in_ready;
    assign out_fire  = out_valid && out_ready;
    assign last      = (cnt == CW'(N - 1));

    // Phase sequencing and the row/column counter shared by all phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_LOAD;
            cnt   <= '0;
        end else begin
            unique case (phase)
                PH_LOAD: if (in_fire) begin
                    cnt <= cnt + 1'b1;
                    if (last) phase <= PH_COL;
                end
                PH_COL: begin
                    cnt <= cnt + 1'b1;
                    if (last) phase <= PH_EMIT;
                end
                PH_EMIT: if (out_fire) begin
                    cnt <= cnt + 1'b1;
                    if (last) phase <= PH_LOAD;
                end
                default: phase <= PH_LOAD;
            endcase
        end
    end

    // Capture both shift amounts with the first row of a tile.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sha_q <= SH_W'(1);
            shb_q <= SH_W'(1);
        end else if (in_fire && cnt == '0) begin
            sha_q <= shift_a;
            shb_q <= shift_b;
        end
    end

    itx8_tile_buf #(.DW(DW)) tile_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .row_we   (in_fire),
        .row_idx  (cnt),
        .row_wdata(in_row),
        .col_we   (phase == PH_COL),
        .col_idx  (cnt),
        .col_wdata(kern_y),
        .row_rdata(row_rd),
        .col_rdata(col_rd)
    );

    // Shared kernel: columns during pass one, rows while emitting.
    assign kern_x  = (phase == PH_COL) ? col_rd : row_rd;
    assign kern_sh = (phase == PH_COL) ? sha_q  : shb_q;

    itx8_butterfly #(.DW(DW), .ACC_W(ACC_W), .SH_W(SH_W)) kern_i (
        .x_flat(kern_x),
        .sh    (kern_sh),
        .y_flat(kern_y)
    );

    assign out_row = kern_y;

    // R8: a stalled result row is held unchanged.
    p_hold_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_row)));

    // R3: accepted shift amounts lie in the legal range.
    p_shift_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_fire && cnt == '0) |-> (shift_a != '0 && shift_b != '0));

    // R3: the held shifts do not move outside the loading phase.
    p_shift_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |=> ($stable(sha_q) && $stable(shb_q)));

    // R2: the eighth accepted row closes the input side.
    p_fill_close_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_fire && last) |=> !in_ready);

    // R9: the eighth output handshake reopens the input side.
    p_drain_open_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_fire && last) |=> (in_ready && !out_valid));
endmodule

// File: tb/itx8_2pass_tb_top.sv
// Bench: behavioural integer model of the 2-D transform, checked row by row.
module itx8_2pass_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;
    localparam int NN = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [4:0] shift_a = 5'd1, shift_b = 5'd1;
    logic in_valid = 1'b0, out_ready = 1'b0;
    logic in_ready, out_valid;
    logic [NN*DW-1:0] in_row = '0;
    logic [NN*DW-1:0] out_row;

    int checks = 0, failures = 0, cyc = 0;
    int cur [NN][NN];
    int expd [NN][NN];

    always #(CLK_PERIOD/2) clk = ~clk;

    itx8_2pass dut_i (
        .clk(clk), .rst_n(rst_n), .shift_a(shift_a), .shift_b(shift_b),
        .in_valid(in_valid), .in_ready(in_ready), .in_row(in_row),
        .out_valid(out_valid), .out_ready(out_ready), .out_row(out_row)
    );

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            failures++;
            $display("FAIL R2 watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int sat16(input int v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    // One 1-D pass of the reference equations, with rounding and clamping.
    task automatic ref1d(input int x[NN], input int s, output int y[NN]);
        int o[4], e[4], r;
        r = 1 << (s - 1);
        o[0] = 89*x[1] + 75*x[3] + 50*x[5] + 18*x[7];
        o[1] = 75*x[1] - 18*x[3] - 89*x[5] - 50*x[7];
        o[2] = 50*x[1] - 89*x[3] + 18*x[5] + 75*x[7];
        o[3] = 18*x[1] - 50*x[3] + 75*x[5] - 89*x[7];
        e[0] = 64*x[0] + 64*x[4] + (84*x[2] + 35*x[6]) + r;
        e[3] = 64*x[0] + 64*x[4] - (84*x[2] + 35*x[6]) + r;
        e[1] = 64*x[0] - 64*x[4] + (35*x[2] - 84*x[6]) + r;
        e[2] = 64*x[0] - 64*x[4] - (35*x[2] - 84*x[6]) + r;
        for (int k = 0; k < 4; k++) begin
            y[k]      = sat16((e[k] + o[k]) >>> s);
            y[NN-1-k] = sat16((e[k] - o[k]) >>> s);
        end
    endtask

    // Columns with shift A (clamped), then rows with shift B (clamped).
    task automatic model(input int sa, input int sb);
        int tmp[NN][NN];
        int x[NN], y[NN];
        for (int c = 0; c < NN; c++) begin
            for (int k = 0; k < NN; k++) x[k] = cur[k][c];
            ref1d(x, sa, y);
            for (int k = 0; k < NN; k++) tmp[k][c] = y[k];
        end
        for (int r = 0; r < NN; r++) begin
            for (int k = 0; k < NN; k++) x[k] = tmp[r][k];
            ref1d(x, sb, y);
            for (int k = 0; k < NN; k++) expd[r][k] = y[k];
        end
    endtask

    // Drive eight rows; optionally disturb the shift inputs after row 0 (R3).
    task automatic send(input int sa, input int sb, input bit disturb);
        int wait_cnt;
        model(sa, sb);
        shift_a = 5'(sa);
        shift_b = 5'(sb);
        for (int r = 0; r < NN; r++) begin
            while (!in_ready) @(negedge clk);
            for (int c = 0; c < NN; c++) in_row[c*DW +: DW] = 16'(cur[r][c]);
            in_valid = 1'b1;
            @(negedge clk);
            if (disturb && r == 0) begin
                shift_a = 5'd1;
                shift_b = 5'd1;
            end
        end
        in_valid = 1'b0;
        chk(!in_ready, "R2", "in_ready after eighth row", int'(in_ready), 0);
        wait_cnt = 0;
        while (!out_valid && wait_cnt < 50) begin
            @(negedge clk);
            wait_cnt++;
        end
        chk(wait_cnt == 8, "R2", "edges from last row to out_valid", wait_cnt, 8);
    endtask

    function automatic bit row_match(input int r, output int col, output int act);
        for (int c = 0; c < NN; c++) begin
            act = int'($signed(out_row[c*DW +: DW]));
            col = c;
            if (act != expd[r][c]) return 1'b0;
        end
        return 1'b1;
    endfunction

    // Collect eight rows with a given stall count before each one.
    task automatic recv(input string req, input int stall);
        int col, act;
        bit ok;
        for (int r = 0; r < NN; r++) begin
            out_ready = 1'b0;
            for (int s = 0; s < stall; s++) begin
                @(negedge clk);
                ok = row_match(r, col, act);
                chk(out_valid && ok, "R8", $sformatf("stalled row %0d col %0d", r, col),
                    act, expd[r][col]);
            end
            while (!out_valid) @(negedge clk);
            ok = row_match(r, col, act);
            chk(ok, req, $sformatf("row %0d col %0d", r, col), act, expd[r][col]);
            out_ready = 1'b1;
            @(negedge clk);
        end
        out_ready = 1'b0;
        chk(in_ready && !out_valid, "R9", "in_ready after eighth output",
            int'(in_ready), 1);
    endtask

    task automatic fill_random(input int lim);
        for (int r = 0; r < NN; r++)
            for (int c = 0; c < NN; c++)
                cur[r][c] = int'($urandom_range(2*lim, 0)) - lim;
    endtask

    task automatic fill_zero();
        for (int r = 0; r < NN; r++)
            for (int c = 0; c < NN; c++)
                cur[r][c] = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
        chk(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);

        // R5: positive DC, smallest shifts.
        fill_zero(); cur[0][0] = 1;
        send(1, 1, 1'b0); recv("R5", 0);

        // R5: negative DC, rounding of negative halves.
        fill_zero(); cur[0][0] = -3;
        send(2, 3, 1'b0); recv("R5", 1);

        // R4: random tiles with typical shifts and varied stalls (R8).
        for (int b = 0; b < 4; b++) begin
            fill_random(2047);
            send(7, 12, 1'b0); recv("R4", b);
        end

        // R4: full-range random tile.
        fill_random(32767);
        send(10, 12, 1'b0); recv("R4", 0);

        // R6: full-scale top row saturates only between the passes.
        fill_zero();
        for (int c = 0; c < NN; c++) cur[0][c] = 32767;
        send(1, 12, 1'b0); recv("R6", 0);

        // R7: a lone maximal coefficient saturates only at the output.
        fill_zero(); cur[0][0] = 32767;
        send(6, 1, 1'b0); recv("R7", 0);
        fill_zero(); cur[0][0] = -32768;
        send(6, 1, 1'b0); recv("R7", 2);

        // R3: shift inputs changed after row 0 must not matter.
        fill_random(2047);
        send(7, 12, 1'b1); recv("R3", 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule